// File: doc/BRIEF.md
# End-of-Write Status Read Path

This block is the read side of a byte-wide nonvolatile memory model. When the chip-select and output-enable pins are low and the write strobe is high, it returns the byte that the storage array holds at the requested address. At all other times it releases the bus. The array is outside this block. The block passes the address to the array and takes the byte that comes back.

While an internal programming cycle is running, the array cannot be read, and the block returns a status word in its place. The top data bit carries the inverse of the top bit of the byte most recently written. The bit just below it changes value at the start of each new read access. The low bits repeat the written byte. A host can use either the inverted bit or the changing bit to detect when programming has finished. Once the busy flag drops, true stored data comes back and the changing bit holds still. All pins are sampled on the system clock, and the data and enable outputs are registered, so they appear one cycle after the pins are sampled.

Top module: `eow_status_read`

## Requirements
- R1: When ce_ni=0, oe_ni=0, we_ni=1 and busy_i=0 are sampled, the next cycle has data_oe_o=1 and data_o equal to the sampled arr_data_i.
- R2: When ce_ni=1 or oe_ni=1 is sampled, the next cycle has data_oe_o=0 and data_o=0.
- R3: When we_ni=0 is sampled, the next cycle has data_oe_o=0, even if ce_ni=0 and oe_ni=0.
- R4: A read sampled with busy_i=1 returns bit 7 (the top data bit) as the inverse of last_wr_i bit 7.
- R5: A read sampled with busy_i=1 returns bits 5:0 equal to last_wr_i bits 5:0, whatever the address and array data.
- R6: A read access starts on the first sampled cycle of a read after a non-read cycle. Each start with busy_i=1 inverts bit 6 relative to the previous busy start. Bit 6 holds while the read stays active. The first busy start after reset returns 1.
- R7: Read starts with busy_i=0 do not change the toggle state. After programming ends, the next busy read returns bit 6 inverted from the last busy read.
- R8: While rst_ni=0, data_oe_o=0 and data_o=0, and the toggle state clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write strobe, active low |
| addr_i | input | ADDR_W | Byte address |
| busy_i | input | 1 | Internal programming cycle in progress |
| last_wr_i | input | DATA_W | Byte most recently written |
| arr_addr_o | output | ADDR_W | Address to the storage array |
| arr_data_i | input | DATA_W | Byte returned by the storage array |
| data_o | output | DATA_W | Read data or status word |
| data_oe_o | output | 1 | Bus drive enable for the tri-state data pins |

## Verification
The bench uses the default widths: 13 address bits and 8 data bits. With these widths the status bits sit at positions 7 and 6, and every case can be driven by name. It holds reads for several cycles during busy, which shows that bit 6 stays stable within one access and inverts between accesses. It also interleaves idle reads between busy phases, which shows that the toggle state survives the gap. Status reads are issued at several addresses, with array data that differs from the written byte.

// File: rtl/eow_pkg.sv
package eow_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE   = 2'd0,
    SRC_ARRAY  = 2'd1,
    SRC_STATUS = 2'd2
  } rd_src_e;
endpackage

// File: rtl/eow_access_detect.sv
module eow_access_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  input  logic we_ni,
  output logic rd_act_o,
  output logic rd_start_o
);
  logic rd_q;

  assign rd_act_o   = ~ce_ni & ~oe_ni & we_ni;
  assign rd_start_o = rd_act_o & ~rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= 1'b0;
    else         rd_q <= rd_act_o;
  end
endmodule

// File: rtl/eow_toggle.sv
module eow_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_start_i,
  input  logic busy_i,
  output logic tog_o
);
  logic tog_q;
  logic flip;

  assign flip  = rd_start_i & busy_i;
  // value seen by the access that starts this cycle
  assign tog_o = tog_q ^ flip;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   tog_q <= 1'b0;
    else if (flip) tog_q <= ~tog_q;
  end
endmodule

// File: rtl/eow_out_stage.sv
module eow_out_stage
  import eow_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_act_i,
  input  logic              busy_i,
  input  logic              tog_i,
  input  logic [DATA_W-1:0] last_wr_i,
  input  logic [DATA_W-1:0] arr_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  rd_src_e           src;
  logic [DATA_W-1:0] status_word;
  logic [DATA_W-1:0] data_d;
  logic [DATA_W-1:0] data_q;
  logic              oe_q;

  always_comb begin
    status_word           = last_wr_i;
    status_word[POLL_BIT] = ~last_wr_i[POLL_BIT];
    status_word[TOG_BIT]  = tog_i;
  end

  always_comb begin
    if (!rd_act_i)   src = SRC_IDLE;
    else if (busy_i) src = SRC_STATUS;
    else             src = SRC_ARRAY;
  end

  always_comb begin
    unique case (src)
      SRC_ARRAY:  data_d = arr_data_i;
      SRC_STATUS: data_d = status_word;
      default:    data_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      data_q <= data_d;
      oe_q   <= rd_act_i;
    end
  end

  assign data_o    = data_q;
  assign data_oe_o = oe_q;
endmodule

// File: rtl/eow_status_read.sv
module eow_status_read #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] last_wr_i,
  output logic [ADDR_W-1:0] arr_addr_o,
  input  logic [DATA_W-1:0] arr_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  logic rd_act;
  logic rd_start;
  logic tog;

  assign arr_addr_o = addr_i;

  eow_access_detect u_detect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_ni      (ce_ni),
    .oe_ni      (oe_ni),
    .we_ni      (we_ni),
    .rd_act_o   (rd_act),
    .rd_start_o (rd_start)
  );

  eow_toggle u_toggle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_start_i (rd_start),
    .busy_i     (busy_i),
    .tog_o      (tog)
  );

  eow_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_act_i   (rd_act),
    .busy_i     (busy_i),
    .tog_i      (tog),
    .last_wr_i  (last_wr_i),
    .arr_data_i (arr_data_i),
    .data_o     (data_o),
    .data_oe_o  (data_oe_o)
  );
endmodule

// File: rtl/eow_status_read_chk.sv
module eow_status_read_chk #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic              we_ni,
  input logic              busy_i,
  input logic [DATA_W-1:0] last_wr_i,
  input logic [DATA_W-1:0] arr_data_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o
);
  logic pin_rd;
  assign pin_rd = !ce_ni && !oe_ni && we_ni;

  AST_ARRAY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_rd && !busy_i) |=> (data_oe_o && data_o == $past(arr_data_i))); // R1
  AST_BUS_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni || oe_ni) |=> (!data_oe_o && data_o == '0)); // R2
  AST_WRITE_INHIBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_ni |=> !data_oe_o); // R3
  AST_POLL_INVERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_rd && busy_i) |=> (data_o[DATA_W-1] == !$past(last_wr_i[DATA_W-1]))); // R4
  AST_STATUS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_rd && busy_i) |=> (data_o[DATA_W-3:0] == $past(last_wr_i[DATA_W-3:0]))); // R5
  AST_TOGGLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_rd && busy_i && data_oe_o) |=> $stable(data_o[DATA_W-2])); // R6
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!data_oe_o && data_o == '0)); // R8
endmodule

bind eow_status_read eow_status_read_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ce_ni      (ce_ni),
  .oe_ni      (oe_ni),
  .we_ni      (we_ni),
  .busy_i     (busy_i),
  .last_wr_i  (last_wr_i),
  .arr_data_i (arr_data_i),
  .data_o     (data_o),
  .data_oe_o  (data_oe_o)
);

// File: tb/eow_status_read_bench.sv
module eow_status_read_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 13;
  localparam int DATA_W = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              ce_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1, busy_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] last_wr_i = '0, arr_data_i = '0;
  logic [ADDR_W-1:0] arr_addr_o;
  logic [DATA_W-1:0] data_o;
  logic              data_oe_o;

  int checks = 0, errors = 0;
  bit tb_tog = 1'b0, tb_prev_rd = 1'b0, done = 1'b0;
  bit              exp_oe[$];
  logic [DATA_W-1:0] exp_d[$];
  string           exp_r[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  eow_status_read #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eow_status_read (
    .clk_i, .rst_ni, .ce_ni, .oe_ni, .we_ni, .addr_i, .busy_i, .last_wr_i,
    .arr_addr_o, .arr_data_i, .data_o, .data_oe_o
  );

  task automatic cyc(input bit ce, input bit oe, input bit we, input bit busy,
                     input logic [7:0] last, input logic [7:0] arr,
                     input logic [12:0] addr, input string req);
    bit rd;
    logic [7:0] d;
    @(negedge clk_i);
    ce_ni = ce; oe_ni = oe; we_ni = we; busy_i = busy;
    last_wr_i = last; arr_data_i = arr; addr_i = addr;
    rd = !ce && !oe && we;
    if (rd && !tb_prev_rd && busy) tb_tog = ~tb_tog;
    tb_prev_rd = rd;
    if (!rd)       d = 8'h00;
    else if (busy) d = {~last[7], tb_tog, last[5:0]};
    else           d = arr;
    exp_oe.push_back(rd); exp_d.push_back(d); exp_r.push_back(req);
  endtask

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual oe/data=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk_i); #1;
      if (exp_r.size() > 0) begin
        bit o; logic [7:0] d; string r;
        o = exp_oe.pop_front(); d = exp_d.pop_front(); r = exp_r.pop_front();
        check(r, {data_oe_o, data_o}, {o, d});
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD*100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    ce_ni = 1'b0; oe_ni = 1'b0; we_ni = 1'b1; arr_data_i = 8'h5A;
    repeat (3) @(posedge clk_i);
    #1 check("R8", {data_oe_o, data_o}, 9'h000); // R8 read pins active in reset
    @(negedge clk_i); ce_ni = 1'b1; rst_ni = 1'b1;
    // R1 array reads, idle
    cyc(0,0,1,0,8'h00,8'hA5,13'h0010,"R1");
    cyc(1,1,1,0,8'h00,8'h11,13'h0011,"R2");
    cyc(0,0,1,0,8'h00,8'h3C,13'h1FFF,"R1");
    cyc(0,0,1,0,8'h00,8'hC3,13'h0000,"R1");
    // R2 deselect cases
    cyc(1,0,1,0,8'h00,8'hFF,13'h0001,"R2");
    cyc(0,1,1,0,8'h00,8'hFF,13'h0002,"R2");
    // R3 write strobe low inhibits drive
    cyc(0,0,0,0,8'h00,8'hFF,13'h0003,"R3");
    cyc(0,0,0,1,8'h81,8'hFF,13'h0003,"R3");
    cyc(1,1,1,1,8'h81,8'hFF,13'h0003,"R2");
    // R4 R5 R6 busy reads; held read keeps bit 6
    cyc(0,0,1,1,8'h81,8'h00,13'h0040,"R4");
    cyc(0,0,1,1,8'h81,8'h00,13'h0041,"R6");
    cyc(0,0,1,1,8'h81,8'h00,13'h0042,"R6");
    cyc(0,1,1,1,8'h81,8'h00,13'h0042,"R2");
    cyc(0,0,1,1,8'h81,8'hFF,13'h1234,"R6");
    cyc(1,0,1,1,8'h81,8'hFF,13'h1234,"R2");
    cyc(0,0,1,1,8'h7E,8'h99,13'h0777,"R5");
    cyc(1,1,1,1,8'h7E,8'h99,13'h0777,"R2");
    cyc(0,0,1,1,8'h2A,8'hD5,13'h0100,"R5");
    cyc(1,1,1,0,8'h2A,8'hD5,13'h0100,"R2");
    // R7 idle reads keep toggle, true data returns
    cyc(0,0,1,0,8'h2A,8'hD5,13'h0100,"R7");
    cyc(1,1,1,0,8'h2A,8'hD5,13'h0100,"R2");
    cyc(0,0,1,0,8'h2A,8'h40,13'h0101,"R7");
    cyc(1,1,1,0,8'h2A,8'h40,13'h0101,"R2");
    cyc(0,0,1,1,8'hC0,8'h00,13'h0200,"R7");
    cyc(0,0,1,1,8'hC0,8'h00,13'h0200,"R6");
    cyc(1,1,1,1,8'hC0,8'h00,13'h0200,"R2");
    // busy drops during a held read: data returns, no flip
    cyc(0,0,1,1,8'hC0,8'h12,13'h0201,"R6");
    cyc(0,0,1,0,8'hC0,8'h12,13'h0201,"R7");
    cyc(0,0,1,1,8'hC0,8'h12,13'h0201,"R6");
    cyc(1,1,1,0,8'hC0,8'h12,13'h0201,"R2");
    // R8 reset clears toggle: first busy read after reset gives bit 6 = 1
    repeat (2) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b0; #1;
    check("R8", {data_oe_o, data_o}, 9'h000);
    exp_oe.delete(); exp_d.delete(); exp_r.delete();
    @(negedge clk_i); rst_ni = 1'b1; tb_tog = 1'b0; tb_prev_rd = 1'b0;
    cyc(0,0,1,1,8'h00,8'h00,13'h0005,"R8");
    cyc(1,1,1,0,8'h00,8'h00,13'h0005,"R2");
    repeat (3) @(posedge clk_i);
    #2;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule